// File: doc/BRIEF.md
# USB Host Port Attach and Bus Reset Controller

This block watches the two single-ended line levels of one USB host port and turns them into a connect status, a speed indication and three sticky event flags. A device counts as attached once one of the two idle levels has stayed unchanged for a minimum debounce time. A full-speed device holds D+ high and a low-speed device holds D- high, and the speed bit records which of the two was seen. A connected device counts as detached once both lines have read SE0 for the same debounce time.

On request the block drives a bus reset: it asserts the SE0 output enable for a fixed number of clock cycles, then drops the request bit by itself and raises a reset-done flag. The host's own reset forces the connect status to 0 but never raises the detach flag. Attach detection starts again after the reset, so the device has to be seen as connected again before any token may be issued.

Durations are counted in cycles of the 48 MHz port clock. The defaults give 2.5 µs of debounce (120 cycles) and 10 ms of reset (480000 cycles). All pins are plain control and status signals with no data stream, so there is no handshake.

Top module: `usb_port_attach_ctrl`

## Requirements
- R1: After reset the connect status, the flags, `irq`, `rst_req` and `se0_oe` are 0. Lines at SE0 ({D+,D-}=00) never produce a connect.
- R2: The connect status rises only after one idle level ({D+,D-}=10 or 01) has been sampled unchanged for DEB_CYC consecutive clock cycles. Any change of line level restarts that count.
- R3: On attach the speed bit `speed_fs` becomes 1 for level 10 (full speed) and 0 for level 01 (low speed). It holds that value until the next attach.
- R4: An attach sets flag bit 0. Writing `flag_wr_data` under `flag_wr_en` clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A flag that is being set in the same cycle stays set.
- R5: A one-cycle `rst_req_set` starts a bus reset. `rst_req` and `se0_oe` then stay 1 for exactly RST_CYC cycles, fall together, and set flag bit 2 in the same cycle.
- R6: The cycle that starts a bus reset forces the connect status to 0, and it stays 0 for the whole reset. This never sets flag bit 1.
- R7: While connected and not in reset, SE0 held for DEB_CYC consecutive cycles clears the connect status and sets flag bit 1. A shorter SE0 changes nothing.
- R8: After a bus reset ends, an idle level present on the lines is debounced again as in R2. It leads to a new connect and to flag bit 0.
- R9: The connect status and the speed bit update whatever `host_mode` is. `rst_req_set` has no effect while `host_mode` is 0.
- R10: `irq` is 1 exactly when some flag bit is 1 and its `irq_en` bit is 1 (bit 0 attach, bit 1 detach, bit 2 reset done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| host_mode | input | 1 | Port operates as host; gates reset requests |
| rst_req_set | input | 1 | Pulse that requests a bus reset |
| flag_wr_en | input | 1 | Write strobe for the flag register |
| flag_wr_data | input | 3 | Write data; a 0 bit clears that flag |
| irq_en | input | 3 | Interrupt enable per flag |
| conn_stat | output | 1 | Device connected |
| speed_fs | output | 1 | 1 full speed, 0 low speed |
| rst_req | output | 1 | Bus reset request bit, self-clearing |
| se0_oe | output | 1 | Drive SE0 onto the bus |
| irq_flags | output | 3 | Sticky flags: attach, detach, reset done |
| irq | output | 1 | Masked interrupt request |

## Verification
Attach is tried with the full-speed level, the low-speed level, and a low-speed level broken by a single SE0 cycle. Together these separate speed decoding from debounce restart, and checks placed just before and just after DEB_CYC catch a debounce that is too short or that never completes. Detach is tried with an SE0 shorter than the debounce and with one longer than it. A bus reset on a connected device tests the reset length, the silent drop of the connect status, and the reconnect that follows. With host mode off, status still updates but reset requests are ignored.

// File: rtl/usbpa_pkg.sv
package usbpa_pkg;
  // {D+, D-} as sampled from the port
  typedef enum logic [1:0] {
    LN_SE0       = 2'b00,
    LN_LOW_IDLE  = 2'b01,
    LN_FULL_IDLE = 2'b10,
    LN_SE1       = 2'b11
  } line_t;

  localparam int unsigned FLG_ATTACH  = 0;
  localparam int unsigned FLG_DETACH  = 1;
  localparam int unsigned FLG_RSTDONE = 2;
  localparam int unsigned FLG_N       = 3;
endpackage

// File: rtl/usbpa_line_watch.sv
module usbpa_line_watch
  import usbpa_pkg::*;
#(
  parameter int unsigned DEB_CYC = 120
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t line_i,
  input  logic  hold_i,
  output logic  conn_o,
  output logic  speed_o,
  output logic  attach_o,
  output logic  detach_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  line_t         line_q;
  logic [CW-1:0] cnt_q;
  logic          wanted, same, hit;

  // Connected: wait for SE0. Not connected: wait for either idle level.
  always_comb begin
    wanted = conn_o ? (line_i == LN_SE0)
                    : (line_i == LN_LOW_IDLE || line_i == LN_FULL_IDLE);
    same   = (line_i == line_q);
    hit    = !hold_i && wanted && same && (cnt_q == LAST);
  end

  assign attach_o = hit && !conn_o;
  assign detach_o = hit && conn_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= LN_SE0;
      cnt_q   <= '0;
      conn_o  <= 1'b0;
      speed_o <= 1'b0;
    end else begin
      line_q <= line_i;
      if (hold_i) begin
        cnt_q  <= '0;
        conn_o <= 1'b0;
      end else if (hit) begin
        cnt_q  <= '0;
        conn_o <= !conn_o;
        if (!conn_o) speed_o <= (line_i == LN_FULL_IDLE);
      end else if (wanted && same) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/usbpa_reset_timer.sv
module usbpa_reset_timer #(
  parameter int unsigned RST_CYC = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (done_o) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usbpa_flag_bank.sv
module usbpa_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_data_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags_o[i] <= 1'b0;
      else if (set_i[i])              flags_o[i] <= 1'b1;
      else if (wr_en_i && !wr_data_i[i]) flags_o[i] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/usb_port_attach_ctrl.sv
module usb_port_attach_ctrl
  import usbpa_pkg::*;
#(
  parameter int unsigned DEB_CYC = 120,
  parameter int unsigned RST_CYC = 480000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_dp,
  input  logic             line_dm,
  input  logic             host_mode,
  input  logic             rst_req_set,
  input  logic             flag_wr_en,
  input  logic [FLG_N-1:0] flag_wr_data,
  input  logic [FLG_N-1:0] irq_en,
  output logic             conn_stat,
  output logic             speed_fs,
  output logic             rst_req,
  output logic             se0_oe,
  output logic [FLG_N-1:0] irq_flags,
  output logic             irq
);
  line_t            line_now;
  logic             busy, start, hold, done_p, att_p, det_p;
  logic [FLG_N-1:0] set_vec;

  assign line_now = line_t'({line_dp, line_dm});
  assign start    = rst_req_set && host_mode && !busy;
  assign hold     = busy || start;

  usbpa_line_watch #(.DEB_CYC(DEB_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .line_i(line_now), .hold_i(hold),
    .conn_o(conn_stat), .speed_o(speed_fs), .attach_o(att_p), .detach_o(det_p)
  );

  usbpa_reset_timer #(.RST_CYC(RST_CYC)) u_rtimer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done_p)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FLG_ATTACH]  = att_p;
    set_vec[FLG_DETACH]  = det_p;
    set_vec[FLG_RSTDONE] = done_p;
  end

  usbpa_flag_bank #(.N(FLG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .wr_en_i(flag_wr_en),
    .wr_data_i(flag_wr_data), .en_i(irq_en), .flags_o(irq_flags), .irq_o(irq)
  );

  assign rst_req = busy;
  assign se0_oe  = busy;
endmodule

// File: rtl/usbpa_checker.sv
module usbpa_checker #(
  parameter int unsigned DEB_CYC = 120,
  parameter int unsigned RST_CYC = 480000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_dp,
  input logic       line_dm,
  input logic       conn_stat,
  input logic       rst_req,
  input logic [2:0] irq_flags,
  input logic [2:0] irq_en,
  input logic       irq
);
  logic [1:0]  ln_prev;
  logic [31:0] stable_cnt, busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_prev    <= 2'b00;
      stable_cnt <= '0;
      busy_cnt   <= '0;
    end else begin
      ln_prev <= {line_dp, line_dm};
      if ({line_dp, line_dm} == ln_prev) begin
        if (stable_cnt != 32'hFFFF_FFFF) stable_cnt <= stable_cnt + 1;
      end else begin
        stable_cnt <= '0;
      end
      busy_cnt <= rst_req ? busy_cnt + 1 : '0;
    end
  end

  AST_ATTACH_DEBOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_stat) |-> (stable_cnt >= DEB_CYC && (line_dp ^ line_dm))); // R2
  AST_NO_CONN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !conn_stat); // R6
  AST_RESET_QUIET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conn_stat) && rst_req) |-> !$rose(irq_flags[1])); // R6
  AST_RESET_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> irq_flags[2]); // R5
  AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (busy_cnt == RST_CYC)); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq); // R10
endmodule

bind usb_port_attach_ctrl usbpa_checker #(.DEB_CYC(DEB_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
  .conn_stat(conn_stat), .rst_req(rst_req), .irq_flags(irq_flags),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/usb_port_attach_ctrl_tb_top.sv
module usb_port_attach_ctrl_tb_top;
  localparam int DEB = 20;
  localparam int RST = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_dp = 1'b0, line_dm = 1'b0;
  logic       host_mode = 1'b1, rst_req_set = 1'b0, flag_wr_en = 1'b0;
  logic [2:0] flag_wr_data = 3'b111, irq_en = 3'b000;
  logic       conn_stat, speed_fs, rst_req, se0_oe, irq;
  logic [2:0] irq_flags;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = !clk;

  usb_port_attach_ctrl #(.DEB_CYC(DEB), .RST_CYC(RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
    .host_mode(host_mode), .rst_req_set(rst_req_set), .flag_wr_en(flag_wr_en),
    .flag_wr_data(flag_wr_data), .irq_en(irq_en), .conn_stat(conn_stat),
    .speed_fs(speed_fs), .rst_req(rst_req), .se0_oe(se0_oe),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lines(input logic dp, input logic dm);
    line_dp = dp;
    line_dm = dm;
  endtask

  task automatic wr_flags(input logic [2:0] d);
    flag_wr_data = d;
    flag_wr_en   = 1'b1;
    wait_n(1);
    flag_wr_en   = 1'b0;
    flag_wr_data = 3'b111;
  endtask

  task automatic t_reset_state;
    chk("R1 conn", conn_stat, 0);
    chk("R1 flags", irq_flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 oe", se0_oe, 0);
    chk("R1 req", rst_req, 0);
    wait_n(3 * DEB);
    chk("R1 se0 stays unconnected", conn_stat, 0);
  endtask

  task automatic t_attach_full;
    set_lines(1, 0);
    wait_n(DEB - 2);
    chk("R2 early conn", conn_stat, 0);
    wait_n(5);
    chk("R2 conn", conn_stat, 1);
    chk("R3 full speed", speed_fs, 1);
    chk("R4 attach flag", irq_flags, 3'b001);
    chk("R10 masked irq", irq, 0);
    irq_en = 3'b001;
    #1;
    chk("R10 enabled irq", irq, 1);
    wr_flags(3'b111);
    chk("R4 write one keeps", irq_flags, 3'b001);
    wr_flags(3'b110);
    chk("R4 write zero clears", irq_flags, 3'b000);
    chk("R10 irq after clear", irq, 0);
    irq_en = 3'b000;
  endtask

  task automatic t_detach;
    set_lines(0, 0);
    wait_n(DEB / 2);
    set_lines(1, 0);
    wait_n(DEB + 5);
    chk("R7 short se0 ignored", conn_stat, 1);
    chk("R7 short se0 no flag", irq_flags, 3'b000);
    set_lines(0, 0);
    wait_n(DEB - 2);
    chk("R7 early detach", conn_stat, 1);
    wait_n(5);
    chk("R7 detached", conn_stat, 0);
    chk("R7 detach flag", irq_flags, 3'b010);
    irq_en = 3'b010;
    #1;
    chk("R10 detach irq", irq, 1);
    irq_en = 3'b000;
    wr_flags(3'b000);
  endtask

  task automatic t_glitch_low;
    set_lines(0, 1);
    wait_n(DEB / 2);
    set_lines(0, 0);
    wait_n(1);
    set_lines(0, 1);
    wait_n(DEB - 2);
    chk("R2 glitch restarts count", conn_stat, 0);
    wait_n(5);
    chk("R2 conn after glitch", conn_stat, 1);
    chk("R3 low speed", speed_fs, 0);
  endtask

  task automatic t_bus_reset;
    wr_flags(3'b000);
    rst_req_set = 1'b1;
    wait_n(1);
    rst_req_set = 1'b0;
    chk("R5 req set", rst_req, 1);
    chk("R5 oe on", se0_oe, 1);
    chk("R6 conn forced low", conn_stat, 0);
    wait_n(RST - 3);
    chk("R5 still driving", se0_oe, 1);
    chk("R6 conn low in reset", conn_stat, 0);
    wait_n(4);
    chk("R5 req self clears", rst_req, 0);
    chk("R5 oe off", se0_oe, 0);
    chk("R5 done flag, R6 no detach", irq_flags, 3'b100);
    chk("R8 not yet reconnected", conn_stat, 0);
    wait_n(DEB + 3);
    chk("R8 reconnected", conn_stat, 1);
    chk("R8 attach flag", irq_flags, 3'b101);
    chk("R8 speed kept", speed_fs, 0);
    wr_flags(3'b000);
  endtask

  task automatic t_no_host;
    host_mode = 1'b0;
    set_lines(0, 0);
    wait_n(DEB + 3);
    chk("R9 detach without host mode", conn_stat, 0);
    set_lines(1, 0);
    wait_n(DEB + 3);
    chk("R9 attach without host mode", conn_stat, 1);
    chk("R9 speed without host mode", speed_fs, 1);
    rst_req_set = 1'b1;
    wait_n(1);
    rst_req_set = 1'b0;
    chk("R9 reset ignored oe", se0_oe, 0);
    chk("R9 reset ignored conn", conn_stat, 1);
    wait_n(RST + 3);
    chk("R9 no done flag", irq_flags[2], 0);
    host_mode = 1'b1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset_state();
    t_attach_full();
    t_detach();
    t_glitch_low();
    t_bus_reset();
    t_no_host();
    finish_run();
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end
endmodule